// File: doc/BRIEF.md
# Slow Oscillator Period Meter

This block measures how long one cycle of a slow, imprecise low-power oscillator lasts. It counts cycles of a fast, accurate reference clock between two successive rising edges of the slow clock. The slow oscillator runs somewhere near 7 to 13 kHz, and its frequency drifts with process, supply and temperature. The reference runs at 19.2 MHz, so one slow period is roughly 1,470 to 2,750 reference ticks. A 12-bit result holds that range comfortably.

Firmware raises the enable, waits for the done flag, and reads the count. It then converts a wanted sleep duration into slow-clock ticks. Lowering the enable clears the flag and the result, so the measurement can be repeated at any time. The slow clock is asynchronous to the reference, so it passes through a synchroniser before its edges are detected. Both the slow edges that bound the measurement pass through the same synchroniser and are delayed equally, so the measured interval is unchanged.

Top module: `lposc_period_meter`

## Requirements
- R1: After reset, `cal_done` is 0 and `period_cnt` is 0.
- R2: With the enable held high, `period_cnt` ends up equal to the number of reference-clock cycles between two consecutive rising edges of `slow_clk`, for any period from 2 up to 4095 cycles, and `cal_done` is then 1.
- R3: Counting begins only at the first synchronised rising edge of `slow_clk` seen after the enable goes high. A partial slow period already in progress when the enable rises is not measured.
- R4: Once `cal_done` is 1 and the enable stays high, `period_cnt` and `cal_done` hold their values. Later slow-clock edges, including edges at a different period, have no effect.
- R5: If no second rising edge arrives within 4095 reference cycles of the first, the count saturates at all ones (4095), `period_cnt` reads 4095, and `cal_done` is set.
- R6: One reference cycle after the enable goes low, `cal_done` and `period_cnt` are both 0. Raising the enable again starts a fresh measurement.
- R7: While the enable is low, `cal_done` stays 0 and `period_cnt` stays 0, whatever the slow clock does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock that the period is counted in |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow oscillator output, asynchronous to clk_ref |
| cal_en | input | 1 | Measurement enable; low clears the result |
| period_cnt | output | CNT_W (12) | Measured slow period in reference cycles |
| cal_done | output | 1 | Result valid |

## Verification
Suppose the counter were stuck, the wrong width, or started one cycle off. The value read at `period_cnt` would then differ from the programmed slow period, and the difference would be visible the moment `cal_done` rises. That is at most about two slow periods after the enable. Suppose the state machine lost track of the held state or the cleared state. The result would then change after completion, or a stale non-zero value would show with the enable low, within one reference cycle. Saturation faults show only with an over-long period, so that case is driven on purpose.

// File: rtl/lposc_period_meter.sv
module lposc_period_meter #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             cal_en,
  output logic [CNT_W-1:0] period_cnt,
  output logic             cal_done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN, ST_HOLD} st_t;

  st_t              state;
  logic [CNT_W-1:0] tick_cnt;
  logic [SYNC_STAGES:0] sync_q;
  logic             slow_rise;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], slow_clk};

  assign slow_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tick_cnt   <= '0;
      period_cnt <= '0;
      cal_done   <= 1'b0;
    end else if (!cal_en) begin
      state      <= ST_IDLE;
      tick_cnt   <= '0;
      period_cnt <= '0;
      cal_done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: state <= ST_ARM;
        ST_ARM:
          if (slow_rise) begin
            tick_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
            state    <= ST_RUN;
          end
        ST_RUN:
          if (slow_rise || tick_cnt == CNT_MAX) begin
            period_cnt <= tick_cnt;
            cal_done   <= 1'b1;
            state      <= ST_HOLD;
          end else begin
            tick_cnt <= tick_cnt + 1'b1;
          end
        default: state <= ST_HOLD;
      endcase
    end
  end

endmodule

module lposc_period_meter_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             cal_en,
  input logic [CNT_W-1:0] period_cnt,
  input logic             cal_done
);

  assert_result_hold_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cal_done && cal_en) |=> (cal_done && $stable(period_cnt)));

  assert_clear_on_disable_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !cal_en |=> (!cal_done && period_cnt == '0));

  assert_idle_quiet_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !cal_done |-> period_cnt == '0);

  assert_nonzero_result_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(cal_done) |-> (period_cnt >= 2 && $past(cal_en)));

endmodule

bind lposc_period_meter lposc_period_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .cal_en(cal_en),
  .period_cnt(period_cnt), .cal_done(cal_done));

// File: tb/tb_lposc_period_meter.sv
`timescale 1ns/1ps
module tb_lposc_period_meter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        cal_en = 1'b0;
  logic [11:0] period_cnt;
  logic        cal_done;

  int total = 0;
  int bad = 0;
  int hi_len = 700;
  int lo_len = 700;
  bit gen_on = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lposc_period_meter dut (
    .clk_ref(clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .cal_en(cal_en), .period_cnt(period_cnt), .cal_done(cal_done));

  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{1, 1, 2}, '{3, 2, 5}, '{700, 700, 1400}, '{1000, 1371, 2371},
    '{600, 900, 1500}, '{1300, 1450, 2750}, '{2047, 2048, 4095}};

  initial begin
    wait (gen_on);
    forever begin
      slow_clk = 1'b1;
      repeat (hi_len) @(negedge clk);
      slow_clk = 1'b0;
      repeat (lo_len) @(negedge clk);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (cal_done) break;
    end
  endtask

  task automatic measure(input int h, input int l, input int exp, input string req);
    @(negedge clk);
    cal_en = 1'b0;
    hi_len = h;
    lo_len = l;
    repeat (2 * (h + l) + 10) @(negedge clk);
    cal_en = 1'b1;
    wait_done(3 * (h + l) + 4200);
    chk(cal_done == 1'b1, req, int'(cal_done), 1);
    chk(int'(period_cnt) == exp, req, int'(period_cnt), exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cal_done == 1'b0, "R1", int'(cal_done), 0);
    chk(period_cnt == 12'd0, "R1", int'(period_cnt), 0);
    rst_n = 1'b1;
    gen_on = 1'b1;

    // R2 table of periods, including the 4095 upper limit
    for (int v = 0; v < NV; v++)
      measure(VEC[v][0], VEC[v][1], VEC[v][2], "R2");

    // R4 result holds while enabled despite a new slow period
    hi_len = 500;
    lo_len = 500;
    repeat (3000) @(negedge clk);
    chk(cal_done == 1'b1, "R4", int'(cal_done), 1);
    chk(period_cnt == 12'd4095, "R4", int'(period_cnt), 4095);

    // R6 clear one cycle after enable drops
    cal_en = 1'b0;
    @(negedge clk);
    chk(cal_done == 1'b0, "R6", int'(cal_done), 0);
    chk(period_cnt == 12'd0, "R6", int'(period_cnt), 0);

    // R7 no activity while disabled
    begin
      int seen = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (cal_done || period_cnt != 0) seen++;
      end
      chk(seen == 0, "R7", seen, 0);
    end

    // R6 fresh measurement after re-enable
    cal_en = 1'b1;
    wait_done(5000);
    chk(int'(period_cnt) == 1000, "R6", int'(period_cnt), 1000);

    // R3 enable mid-high phase: partial period must not be counted
    @(negedge clk);
    cal_en = 1'b0;
    hi_len = 800;
    lo_len = 800;
    repeat (3300) @(negedge clk);
    @(posedge slow_clk);
    repeat (300) @(negedge clk);
    cal_en = 1'b1;
    repeat (1200) @(negedge clk);
    chk(cal_done == 1'b0, "R3", int'(cal_done), 0);
    wait_done(5000);
    chk(int'(period_cnt) == 1600, "R3", int'(period_cnt), 1600);

    // R5 saturation with a period beyond the counter range
    measure(3000, 3000, 4095, "R5");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule